// File: doc/BRIEF.md
# Dual-Slope / Single-Slope PWM Waveform Generator

This block is a 16-bit timer with a single output-compare channel that produces a pulse-width-modulated waveform. It counts only on cycles where an external tick enable is high, so any prescaler sits outside it. Two counting styles are offered. In single-slope operation the counter climbs to a ceiling value and wraps to zero. In dual-slope operation it climbs to the ceiling and then descends to zero, which gives pulses centred in the period.

The ceiling is one of three fixed widths (255, 511 or 1023), a separately written ceiling register, or the compare register itself. Both the compare value and the ceiling register are written through a small write port into holding buffers. The buffers are copied into the working registers only at the ceiling, so software may write at any moment without producing a torn period. A two-bit output-mode input selects one of four behaviours: no output, toggle on match, non-inverted PWM or inverted PWM.

Top module: `pwm_wavegen`

## Requirements
- R1: While `rst` is high, at the following clock edge `count` becomes 0, `wave` and `ovf` become 0, and the count direction becomes upward. The first tick after reset therefore moves `count` to 1 in either slope mode.
- R2: `count` changes only at clock edges where `tick` was high. With `tick` low, `count` holds.
- R3: When `dual_slope`=0, each tick advances `count` by one. A tick at or above the ceiling sets `count` to 0 instead, and `ovf` is high for the one cycle after that edge. The `top_sel` encoding is 0 for 255, 1 for 511, 2 for 1023, 3 for the ceiling register, and 4 for the compare register. Codes 5 to 7 act as 0.
- R4: With `dual_slope`=0 and `com_mode`=2 (non-inverted), the output is set on the wrap tick and cleared on the tick where `count` equals the compare value. A wrap takes priority over a match. Each period of TOP+1 ticks has compare+1 ticks high. This gives a single-tick spike at compare 0 and a constant high level at compare = TOP.
- R5: With `dual_slope`=0 and `com_mode`=3 (inverted), the output is the complement of R4. It is high for TOP-compare ticks per period, and constant low at compare = TOP.
- R6: When `dual_slope`=1, `count` runs 0,1,…,TOP,TOP-1,…,1,0 with a period of 2·TOP ticks. `ovf` is high for one cycle after each tick that brings `count` down to 0.
- R7: With `dual_slope`=1, a match on a rising step clears the output and a match on a falling step sets it. The tick at TOP and the tick at the bottom turn-around count as falling and rising respectively. `com_mode`=3 inverts this. Each period is high for 2·compare ticks in non-inverted mode and 2·(TOP-compare) ticks in inverted mode.
- R8: In dual-slope mode a ceiling below 3 is raised to 3.
- R9: A write with `wr_en`=1 goes into a holding buffer. `wr_addr`=0 selects the compare buffer and `wr_addr`=1 selects the ceiling buffer. The buffers are copied into the working registers only on the tick at the ceiling: the wrap tick in single-slope mode and the peak tick in dual-slope mode.
- R10: With `com_mode`=1 and `top_sel`=4, the output inverts on every match tick. A compare of N gives 50% duty over 2·(N+1) ticks, and a compare of 0 gives a toggle on every tick. `com_mode`=1 with any other `top_sel`, and `com_mode`=2 or 3 with `top_sel`=4, hold `wave` low.
- R11: `com_mode`=0 holds `wave` low from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable from an external prescaler |
| wr_en | input | 1 | Write strobe for the holding buffers |
| wr_addr | input | 1 | 0 = compare buffer, 1 = ceiling buffer |
| wr_data | input | 16 | Value to write |
| dual_slope | input | 1 | 0 = single-slope, 1 = up/down counting |
| top_sel | input | 3 | Ceiling source (see R3) |
| com_mode | input | 2 | 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| wave | output | 1 | Waveform output |
| ovf | output | 1 | One-cycle pulse when the counter reaches zero |
| count | output | 16 | Current counter value |

## Verification
The single-slope and dual-slope compare paths are each swept over every compare value from 0 to TOP on a small programmed ceiling, in both polarities. The high-tick count per period separates an off-by-one in the match tick, a wrong priority between wrap and match, and the wrong slope being treated as rising. Each fixed ceiling width is run for a full period to check the wrap point. A write placed in the middle of a period shows whether the duty or the period length changes before the next ceiling, which is what separates a buffered register from a direct one. Alternating tick pulses, the toggle mode with compare 9 and compare 0, and the disconnected modes cover gating and the hold-low cases.

// File: rtl/pwm_wavegen_pkg.sv
package pwm_wavegen_pkg;
    // ceiling source codes
    localparam logic [2:0] TSEL_FIX8  = 3'd0;
    localparam logic [2:0] TSEL_FIX9  = 3'd1;
    localparam logic [2:0] TSEL_FIX10 = 3'd2;
    localparam logic [2:0] TSEL_REG   = 3'd3;
    localparam logic [2:0] TSEL_CMP   = 3'd4;

    // output behaviour codes
    localparam logic [1:0] OUT_OFF    = 2'd0;
    localparam logic [1:0] OUT_TOGGLE = 2'd1;
    localparam logic [1:0] OUT_NONINV = 2'd2;
    localparam logic [1:0] OUT_INV    = 2'd3;

    // write port targets
    localparam logic ADDR_CMP = 1'b0;
    localparam logic ADDR_TOP = 1'b1;
endpackage

// File: rtl/pwm_wave_shadow.sv
module pwm_wave_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load,
    output logic [CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0] top_act
);
    import pwm_wavegen_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cmp_buf;
        logic [CNT_W-1:0] top_buf;
        logic [CNT_W-1:0] cmp_act;
        logic [CNT_W-1:0] top_act;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // working copies take the buffers as they stood before this edge
        if (load) begin
            s_d.cmp_act = s_q.cmp_buf;
            s_d.top_act = s_q.top_buf;
        end
        if (wr_en) begin
            if (wr_addr == ADDR_CMP) s_d.cmp_buf = wr_data;
            else                     s_d.top_buf = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cmp_act = s_q.cmp_act;
    assign top_act = s_q.top_act;
endmodule

// File: rtl/pwm_wave_counter.sv
module pwm_wave_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             dual,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic             ovf,
    output logic             peak
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       at_ceiling;

    always_comb begin
        at_ceiling = (s_q.cnt >= top);
        peak       = tick && at_ceiling && !(dual && s_q.down);
        s_d        = s_q;
        s_d.ovf    = 1'b0;
        if (tick) begin
            if (!dual) begin
                s_d.down = 1'b0;
                if (at_ceiling) begin
                    s_d.cnt = '0;
                    s_d.ovf = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end else if (!s_q.down) begin
                if (at_ceiling) begin
                    s_d.down = 1'b1;
                    s_d.cnt  = s_q.cnt - CNT_W'(1);
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end else begin
                if (s_q.cnt == '0) begin
                    s_d.down = 1'b0;
                    s_d.cnt  = CNT_W'(1);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                    s_d.ovf = (s_q.cnt == CNT_W'(1));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt  = s_q.cnt;
    assign down = s_q.down;
    assign ovf  = s_q.ovf;
endmodule

// File: rtl/pwm_wave_outgen.sv
module pwm_wave_outgen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             dual,
    input  logic             down,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] top,
    input  logic [1:0]       com,
    input  logic             cmp_is_top,
    output logic             wave
);
    import pwm_wavegen_pkg::*;

    logic wave_d, wave_q;
    logic match, wrap, rising, connected, set_ev, clr_ev;

    always_comb begin
        match  = tick && (cnt == cmp);
        wrap   = tick && !dual && (cnt >= top);
        // peak tick counts as falling, bottom turn-around as rising
        rising = dual ? ((!down && (cnt < top)) || (down && (cnt == '0))) : 1'b1;
        if (com == OUT_TOGGLE) connected = cmp_is_top;
        else                   connected = (com != OUT_OFF) && !cmp_is_top;
        set_ev = wrap || (dual && match && !rising);
        clr_ev = match && rising && !wrap;

        wave_d = wave_q;
        if (!connected) begin
            wave_d = 1'b0;
        end else if (com == OUT_TOGGLE) begin
            if (match) wave_d = !wave_q;
        end else if (set_ev) begin
            wave_d = (com == OUT_NONINV);
        end else if (clr_ev) begin
            wave_d = (com == OUT_INV);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wave_q <= 1'b0;
        else     wave_q <= wave_d;
    end

    assign wave = wave_q;
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen #(
    parameter int CNT_W        = 16,  // at least 10 for the fixed ceilings
    parameter int MIN_DUAL_TOP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             dual_slope,
    input  logic [2:0]       top_sel,
    input  logic [1:0]       com_mode,
    output logic             wave,
    output logic             ovf,
    output logic [CNT_W-1:0] count
);
    import pwm_wavegen_pkg::*;

    localparam logic [CNT_W-1:0] FIX8_TOP  = CNT_W'((1 << 8) - 1);
    localparam logic [CNT_W-1:0] FIX9_TOP  = CNT_W'((1 << 9) - 1);
    localparam logic [CNT_W-1:0] FIX10_TOP = CNT_W'((1 << 10) - 1);
    localparam logic [CNT_W-1:0] DUAL_FLOOR = CNT_W'(MIN_DUAL_TOP);

    logic [CNT_W-1:0] cmp_act, topr_act, top_raw, top_eff;
    logic             peak, down;
    logic             cmp_is_top;

    always_comb begin
        cmp_is_top = (top_sel == TSEL_CMP);
        case (top_sel)
            TSEL_FIX9:  top_raw = FIX9_TOP;
            TSEL_FIX10: top_raw = FIX10_TOP;
            TSEL_REG:   top_raw = topr_act;
            TSEL_CMP:   top_raw = cmp_act;
            default:    top_raw = FIX8_TOP;
        endcase
        top_eff = (dual_slope && (top_raw < DUAL_FLOOR)) ? DUAL_FLOOR : top_raw;
    end

    pwm_wave_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (peak),
        .cmp_act (cmp_act),
        .top_act (topr_act)
    );

    pwm_wave_counter #(.CNT_W(CNT_W)) u_counter (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .dual (dual_slope),
        .top  (top_eff),
        .cnt  (count),
        .down (down),
        .ovf  (ovf),
        .peak (peak)
    );

    pwm_wave_outgen #(.CNT_W(CNT_W)) u_outgen (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .dual       (dual_slope),
        .down       (down),
        .cnt        (count),
        .cmp        (cmp_act),
        .top        (top_eff),
        .com        (com_mode),
        .cmp_is_top (cmp_is_top),
        .wave       (wave)
    );
endmodule

// File: rtl/pwm_wavegen_chk.sv
module pwm_wavegen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             dual_slope,
    input logic [2:0]       top_sel,
    input logic [1:0]       com_mode,
    input logic             wave,
    input logic             ovf,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] top_eff,
    input logic [CNT_W-1:0] cmp_act
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !wave && !ovf));

    p_tick_gate_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    p_fast_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !dual_slope && count >= top_eff) |=> (count == '0));

    p_ovf_bottom_r3: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (count == '0));

    p_ovf_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(tick));

    p_cmp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cmp_act));

    p_toggle_r10: assert property (@(posedge clk) disable iff (rst)
        (com_mode == 2'd1 && top_sel == 3'd4 && tick && count == cmp_act)
        |=> (wave != $past(wave)));

    p_off_low_r11: assert property (@(posedge clk) disable iff (rst)
        (com_mode == 2'd0) |=> !wave);
endmodule

bind pwm_wavegen pwm_wavegen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .dual_slope (dual_slope),
    .top_sel    (top_sel),
    .com_mode   (com_mode),
    .wave       (wave),
    .ovf        (ovf),
    .count      (count),
    .top_eff    (top_eff),
    .cmp_act    (cmp_act)
);

// File: tb/pwm_wavegen_test.sv
module pwm_wavegen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        dual_slope = 1'b0;
    logic [2:0]  top_sel = 3'd0;
    logic [1:0]  com_mode = 2'd0;
    logic        wave, ovf;
    logic [15:0] count;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pwm_wavegen uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dual_slope(dual_slope), .top_sel(top_sel),
        .com_mode(com_mode), .wave(wave), .ovf(ovf), .count(count)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic wr(input bit a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // advance to the k-th following sample that shows ovf
    task automatic sync(input int k);
        repeat (k) begin
            do @(negedge clk); while (!ovf);
        end
    endtask

    // starts on an ovf sample; ends on the sample after the period
    task automatic measure(input int n, input bit dl, input int tp,
                           input int wr_at, input bit wa, input int wd,
                           output int highs, output int seq_bad,
                           output int ovf_cnt, output bit wrap_ok);
        highs = 0; seq_bad = 0; ovf_cnt = 0;
        for (int i = 0; i < n; i++) begin
            int ec;
            if (i > 0) begin @(negedge clk); wr_en = 1'b0; end
            ec = (dl && i > tp) ? 2 * tp - i : i;
            if (int'(count) != ec) seq_bad++;
            if (ovf) ovf_cnt++;
            if (wave) highs++;
            if (i == wr_at) begin wr_en = 1'b1; wr_addr = wa; wr_data = 16'(wd); end
        end
        @(negedge clk);
        wr_en = 1'b0;
        wrap_ok = ovf && (count == 16'd0);
    endtask

    task automatic period_check(input string seq_tag, input string duty_tag,
                                input int n, input bit dl, input int tp,
                                input int exp_highs);
        int h, sb, oc;
        bit wok;
        measure(n, dl, tp, -1, 1'b0, 0, h, sb, oc, wok);
        chk(sb == 0, seq_tag, "count sequence mismatches", sb, 0);
        chk(oc == 1, seq_tag, "ovf samples in period", oc, 1);
        chk(wok, seq_tag, "return to zero with ovf", int'(wok), 1);
        if (exp_highs >= 0) chk(h == exp_highs, duty_tag, "high ticks", h, exp_highs);
    endtask

    task automatic low_window(input string tag, input int n);
        int h = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wave) h++;
        end
        chk(h == 0, tag, "high samples while held low", h, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int h1, h2, sb, oc, alt_bad;
        bit wok, prev;

        // R1: reset state
        dual_slope = 1'b1; com_mode = 2'd2;
        repeat (3) @(negedge clk);
        chk(count == 16'd0, "R1", "count in reset", int'(count), 0);
        chk(wave == 1'b0, "R1", "wave in reset", int'(wave), 0);
        chk(ovf == 1'b0, "R1", "ovf in reset", int'(ovf), 0);
        rst = 1'b0;

        // R2: no tick, no movement
        repeat (5) @(negedge clk);
        chk(count == 16'd0, "R2", "count without tick", int'(count), 0);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk(count == 16'd1, "R1", "first step after reset is upward", int'(count), 1);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
        end
        chk(count == 16'd5, "R2", "count after five isolated ticks", int'(count), 5);

        // R3: fixed ceilings, single slope
        tick = 1'b1; dual_slope = 1'b0;
        top_sel = 3'd0; sync(2); period_check("R3", "R3", 256, 1'b0, 255, -1);
        top_sel = 3'd1; sync(2); period_check("R3", "R3", 512, 1'b0, 511, -1);
        top_sel = 3'd2; sync(2); period_check("R3", "R3", 1024, 1'b0, 1023, -1);
        top_sel = 3'd5; sync(2); period_check("R3", "R3", 256, 1'b0, 255, -1);

        // R4 / R5: single-slope sweep with ceiling register 7
        top_sel = 3'd3; wr(1'b1, 7);
        for (int c = 0; c <= 7; c++) begin
            com_mode = 2'd2; wr(1'b0, c); sync(3);
            period_check("R3", "R4", 8, 1'b0, 7, c + 1);
        end
        for (int c = 0; c <= 7; c++) begin
            com_mode = 2'd3; wr(1'b0, c); sync(3);
            period_check("R3", "R5", 8, 1'b0, 7, 7 - c);
        end

        // R6 / R7: dual-slope sweep with ceiling register 6
        dual_slope = 1'b1; wr(1'b1, 6);
        for (int c = 0; c <= 6; c++) begin
            com_mode = 2'd2; wr(1'b0, c); sync(3);
            period_check("R6", "R7", 12, 1'b1, 6, 2 * c);
        end
        for (int c = 0; c <= 6; c++) begin
            com_mode = 2'd3; wr(1'b0, c); sync(3);
            period_check("R6", "R7", 12, 1'b1, 6, 2 * (6 - c));
        end

        // R8: ceiling below the dual-slope floor
        wr(1'b1, 1); sync(3);
        period_check("R8", "R8", 6, 1'b1, 3, -1);

        // R9: buffered compare and ceiling
        dual_slope = 1'b0; com_mode = 2'd2;
        wr(1'b1, 7); wr(1'b0, 2); sync(3);
        measure(8, 1'b0, 7, 2, 1'b0, 6, h1, sb, oc, wok);
        chk(h1 == 3, "R9", "duty keeps old compare in write period", h1, 3);
        measure(8, 1'b0, 7, -1, 1'b0, 0, h2, sb, oc, wok);
        chk(h2 == 7, "R9", "duty uses new compare next period", h2, 7);
        measure(8, 1'b0, 7, 2, 1'b1, 4, h1, sb, oc, wok);
        chk(sb == 0 && wok, "R9", "period keeps old ceiling in write period", sb, 0);
        measure(5, 1'b0, 4, -1, 1'b0, 0, h1, sb, oc, wok);
        chk(sb == 0 && wok, "R9", "period uses new ceiling next period", sb, 0);

        // R10: toggle with compare as ceiling
        top_sel = 3'd4; com_mode = 2'd1; wr(1'b0, 9); sync(3);
        measure(10, 1'b0, 9, -1, 1'b0, 0, h1, sb, oc, wok);
        chk(sb == 0 && wok, "R10", "count sequence with compare ceiling", sb, 0);
        measure(10, 1'b0, 9, -1, 1'b0, 0, h2, sb, oc, wok);
        chk((h1 == 10 && h2 == 0) || (h1 == 0 && h2 == 10), "R10",
            "high ticks in first of two toggle periods", h1, 10 - h2);
        wr(1'b0, 0); sync(3);
        alt_bad = 0;
        prev = wave;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (wave == prev || count != 16'd0) alt_bad++;
            prev = wave;
        end
        chk(alt_bad == 0, "R10", "samples without a toggle at compare 0", alt_bad, 0);
        com_mode = 2'd2; low_window("R10", 20);
        com_mode = 2'd1; top_sel = 3'd3; wr(1'b1, 7); low_window("R10", 20);

        // R11: output disconnected
        com_mode = 2'd0; wr(1'b0, 3); low_window("R11", 20);
        dual_slope = 1'b1; low_window("R11", 20);

        summary();
        $finish;
    end
endmodule